// File: doc/BRIEF.md
# Comma-Aligned Receive Framer

This block sits behind a serial line receiver. It takes one recovered bit per bit clock into a 10-bit shifter and cuts the stream into 10-bit symbols. A modulo-10 boundary counter sets where each symbol is delivered. The block finds the correct boundary by looking for the comma that opens a K28.5 control symbol. Each delivered symbol comes with a one-cycle valid strobe. A sticky indicator goes high once a comma has been delivered on the boundary.

An enable input controls realignment. While the enable is high, a comma found off the boundary moves the boundary to that comma. While the enable is low, the counter runs on unchanged, so a bit error that forms a false comma cannot shift the boundary. Once the enable has stayed high across 2048 deliveries in a row, the block uses a stricter double-symbol rule. Under that rule it realigns only after two commas, ten bits apart, agree on the same new boundary. Dropping the enable clears the run count, and the block goes back to the single-comma rule.

Top module: `comma_framer`

## Requirements
- R1: During reset `sym_valid` is 0, `framed` is 0 and `sym_out` is 0. After reset is released, the first delivery falls on the 10th rising edge.
- R2: When no realignment takes place, `sym_valid` is high for exactly one cycle in every ten. Deliveries never start or stop on their own.
- R3: A comma is present when the first seven received bits of the 10-bit window are 0011111 or 1100000. Either running-disparity form is accepted. The first received bit is written leftmost.
- R4: In single mode with the enable high, a comma off the current boundary causes a delivery on the edge after its last bit is captured. Later deliveries follow every ten edges from that point.
- R5: With the enable low, commas at any offset never move the delivery boundary.
- R6: Each delivered symbol holds the ten bits captured on the ten edges before the delivery edge. The earliest of these bits is in `sym_out[9]`.
- R7: After 2048 deliveries made with the enable held high throughout, double mode is entered. In double mode a single off-boundary comma leaves the boundary unchanged.
- R8: In double mode, two commas ten bits apart at the same new offset move the boundary. The delivery occurs on the edge after the second comma's last bit.
- R9: Any cycle with the enable low clears the delivery run count and leaves double mode. After the enable returns high, a single off-boundary comma realigns again.
- R10: `framed` rises together with the delivery of a symbol that starts with a comma. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data, one bit per clock |
| reframe_en | input | 1 | High allows commas to move the boundary |
| sym_out | output | 10 | Delivered symbol, earliest bit in bit 9 |
| sym_valid | output | 1 | One-cycle strobe marking a new `sym_out` |
| framed | output | 1 | Sticky: a comma has been delivered on the boundary |

## Verification
A symbol is due on the rising edge after the tenth bit of its window has been captured. An accepted realignment is due on the edge directly after the comma's last bit, so each result appears one register stage after its stimulus. The bench keeps an edge count and a history of every bit it drives. It samples the outputs 2 ns after every rising edge, and in that cycle it checks both whether a delivery was due and what the delivered symbol should hold. It places commas at chosen offsets relative to its own predicted boundary, and it tracks the enable-high delivery run itself to know when double mode applies.

// File: rtl/comma_framer.sv
module comma_framer #(
  parameter int SYM_W      = 10,
  parameter int LOCK_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             reframe_en,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_valid,
  output logic             framed
);
  localparam int CW = $clog2(SYM_W);
  localparam int RW = $clog2(LOCK_BYTES + 1);
  localparam logic [6:0] PFX_NEG = 7'b0011111;
  localparam logic [6:0] PFX_POS = 7'b1100000;
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);
  localparam logic [RW-1:0] RUN_END = RW'(LOCK_BYTES - 1);

  logic [SYM_W-1:0] shf;
  logic [CW-1:0]    phase;
  logic [CW-1:0]    ptmr;
  logic             pend;
  logic             dbl;
  logic [RW-1:0]    run;

  logic comma, bound, stray, second, realign, take;

  assign comma   = (shf[SYM_W-1 -: 7] == PFX_NEG) || (shf[SYM_W-1 -: 7] == PFX_POS);
  assign bound   = (phase == LAST);
  assign stray   = comma && !bound;
  assign second  = pend && (ptmr == '0) && stray;
  assign realign = reframe_en && stray && (dbl ? second : 1'b1);
  assign take    = bound || realign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf       <= '0;
      phase     <= '0;
      sym_out   <= '0;
      sym_valid <= 1'b0;
      framed    <= 1'b0;
    end else begin
      shf       <= {shf[SYM_W-2:0], bit_in};
      phase     <= take ? '0 : phase + 1'b1;
      sym_valid <= take;
      if (take) sym_out <= shf;
      if (take && comma) framed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ptmr <= '0;
    end else if (!reframe_en || !dbl || realign) begin
      pend <= 1'b0;
    end else if (stray && !pend) begin
      pend <= 1'b1;
      ptmr <= LAST;
    end else if (pend) begin
      if (ptmr == '0) pend <= 1'b0;
      else ptmr <= ptmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      dbl <= 1'b0;
    end else if (!reframe_en) begin
      run <= '0;
      dbl <= 1'b0;
    end else if (take && !dbl) begin
      run <= run + 1'b1;
      if (run == RUN_END) dbl <= 1'b1;
    end
  end

  assert_locked_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reframe_en && !bound) |=> !sym_valid);

  assert_single_realign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reframe_en && !dbl && stray) |=>
      (sym_valid && ((sym_out[SYM_W-1 -: 7] == PFX_NEG) || (sym_out[SYM_W-1 -: 7] == PFX_POS))));

  assert_lone_comma_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reframe_en && dbl && stray && !pend) |=> !sym_valid);

  assert_mode_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbl) |-> $past(reframe_en));

  assert_pair_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reframe_en && dbl && second) |=> sym_valid);

  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reframe_en |=> !dbl);

  assert_framed_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    framed |=> framed);
endmodule

// File: tb/test_comma_framer.sv
module test_comma_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       reframe_en = 1'b0;
  logic [9:0] sym_out;
  logic       sym_valid;
  logic       framed;

  int    nchk = 0;
  int    nerr = 0;
  bit    bitv [0:32767];
  int    t_edge = 0;
  int    exp_take = 10;
  int    realign_at = 0;
  int    last_edge = 0;
  int    run_b = 0;
  logic  lastb = 1'b0;
  int    rl = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  comma_framer i_comma_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .reframe_en (reframe_en),
    .sym_out    (sym_out),
    .sym_valid  (sym_valid),
    .framed     (framed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, t_edge, act, exp);
    end
  endtask

  function automatic logic [9:0] window(input int t);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[9-i] = bitv[t-10+i];
    return w;
  endfunction

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      t_edge = 0;
    end else begin
      bit due;
      t_edge++;
      due = (t_edge == exp_take) || (t_edge == realign_at);
      chk(sym_valid == due, tag, int'(sym_valid), int'(due));
      if (sym_valid) begin
        chk(sym_out == window(t_edge), "R6", int'(sym_out), int'(window(t_edge)));
      end
      if (!reframe_en) run_b = 0;
      else if (sym_valid) run_b++;
      if (t_edge == realign_at) begin
        exp_take = t_edge + 10;
        realign_at = 0;
      end else if (t_edge == exp_take) begin
        exp_take = t_edge + 10;
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    last_edge = t_edge + 1;
    bitv[last_edge] = b;
    if (b == lastb) rl++;
    else rl = 1;
    lastb = b;
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = logic'($urandom % 2);
      if (rl >= 3 && b == lastb) b = ~lastb;
      send_bit(b);
    end
  endtask

  task automatic send_k(input bit pol, output int c);
    logic [9:0] k;
    k = pol ? 10'b1100000101 : 10'b0011111010;
    for (int i = 9; i >= 0; i--) send_bit(k[i]);
    c = last_edge;
  endtask

  task automatic lead_in(input int off);
    int pad;
    pad = ((exp_take + off - (last_edge + 1) - 11) % 10 + 10) % 10;
    send_data(pad);
  endtask

  task automatic stray_comma(input bit pol, input int off, input bit realigns);
    int c;
    lead_in(off);
    send_bit(pol ? 1'b0 : 1'b1);
    send_k(pol, c);
    if (realigns) realign_at = c + 1;
  endtask

  task automatic comma_pair(input int off);
    int c1, c2;
    lead_in(off);
    send_bit(1'b1);
    send_k(1'b0, c1);
    send_k(1'b1, c2);
    realign_at = c2 + 1;
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(sym_valid == 1'b0, "R1", int'(sym_valid), 0);
    chk(framed == 1'b0, "R1", int'(framed), 0);
    chk(sym_out == 10'd0, "R1", int'(sym_out), 0);
    rst_n = 1'b1;
    send_data(14);
    tag = "R2";
    send_data(50);

    tag = "R5";
    stray_comma(1'b0, 4, 1'b0);
    send_data(20);
    chk(framed == 1'b0, "R5", int'(framed), 0);
    stray_comma(1'b1, 7, 1'b0);
    send_data(20);
    chk(framed == 1'b0, "R10", int'(framed), 0);

    tag = "R10";
    stray_comma(1'b0, 0, 1'b0);
    send_data(3);
    chk(framed == 1'b1, "R10", int'(framed), 1);
    send_data(20);

    reframe_en = 1'b1;
    tag = "R4";
    stray_comma(1'b0, 3, 1'b1);
    send_data(25);
    tag = "R3";
    stray_comma(1'b1, 6, 1'b1);
    send_data(25);
    tag = "R4";
    for (int i = 0; i < 6; i++) begin
      stray_comma(1'($urandom % 2), 1 + int'($urandom % 9), 1'b1);
      send_data(15 + int'($urandom % 20));
    end
    chk(framed == 1'b1, "R10", int'(framed), 1);

    tag = "R7";
    while (run_b < 2060) send_data(10);
    stray_comma(1'b0, 5, 1'b0);
    send_data(30);
    stray_comma(1'b1, 2, 1'b0);
    send_data(30);

    tag = "R8";
    comma_pair(4);
    send_data(30);
    comma_pair(8);
    send_data(30);

    reframe_en = 1'b0;
    tag = "R9";
    send_data(30);
    reframe_en = 1'b1;
    stray_comma(1'b0, 6, 1'b1);
    send_data(30);
    stray_comma(1'b1, 3, 1'b1);
    send_data(30);

    finish_up();
  end
endmodule